// File: doc/BRIEF.md
# Burst-Limited FIFO Transfer Engine

This engine moves a buffer of any length between a byte stream on the user side and the data FIFO of a device. The device sits behind a transaction framer. The device says how many bytes it will take in one go through a 16-bit burst count held in its 32-bit status register. Before every chunk the engine asks the framer for a 4-byte read of that register. It rebuilds the word from bytes that arrive least significant first and pulls out the burst count. A count of zero means the device is busy, and the engine reads the register again.

When the count is usable, the chunk size is the smallest of three values: the bytes still owed, the burst count, and the 64-byte limit of one frame. The engine then asks the framer for one FIFO transaction of exactly that size, read or write as chosen at start. It passes the payload bytes straight through between the framer and the user stream, and it counts them. The loop stops when the count of moved bytes equals the requested length. The engine then pulses `done`. If the device stays busy for too many status reads in a row, the engine pulses `error` and goes back to idle.

Top module: `fifo_burst_mover`

## Requirements
- R1: During reset and just after it, the engine requests no transaction, and `done`, `error`, `usr_tx_take` and `usr_rx_valid` are all low.
- R2: Every chunk is preceded by a status read: a request with `frm_read`=1, `frm_size`=4 and `frm_addr`=`STS_ADDR` (offset 0x18). The request holds its fields steady until `frm_ack`.
- R3: The four status bytes arrive least significant byte first. The burst count is bits 23:8 of the word they form. Bits 31:24 and 7:0 have no effect on it.
- R4: A status read whose burst count is zero is followed by another status read, not by a FIFO transaction.
- R5: Each FIFO transaction size equals min(bytes remaining, burst count from the status read just before it, FRAME_MAX). FRAME_MAX is 64 by default.
- R6: Each FIFO transaction is addressed to `FIFO_ADDR` (offset 0x24), with `frm_read` equal to the `dir_read` value captured at start (1 = device to user, 0 = user to device).
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the final payload byte. The total of all chunk sizes equals `total_len`, and no request follows.
- R8: A start with `total_len`=0 raises `done` in the next cycle and makes no request at all.
- R9: After MAX_ZERO status reads in a row that report zero, `error` pulses for one cycle, no request follows, and `done` stays low. Any non-zero read resets this run count. So does a new start.
- R10: During a read FIFO transaction, every framer byte is forwarded on `usr_rx_valid`/`usr_rx_data`. Status bytes are never forwarded.
- R11: During a write FIFO transaction, `usr_tx_take` is high exactly when `frm_tx_ready` is high, and `frm_tx_data` carries `usr_tx_data`.
- R12: A `start` seen while a transfer is in progress has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| dir_read | input | 1 | 1: device FIFO to user, 0: user to device FIFO |
| total_len | input | LEN_W | Number of bytes to move |
| done | output | 1 | One-cycle pulse when the whole length has moved |
| error | output | 1 | One-cycle pulse when the busy-retry limit is reached |
| frm_req | output | 1 | Transaction request to the framer |
| frm_read | output | 1 | Requested transaction is a read |
| frm_addr | output | ADDR_W | Register address of the request |
| frm_size | output | SIZE_W | Byte count of the request (1..FRAME_MAX) |
| frm_ack | input | 1 | Framer accepts the current request |
| frm_rx_valid | input | 1 | Framer delivers one byte read from the device |
| frm_rx_data | input | 8 | Byte read from the device |
| frm_tx_ready | input | 1 | Framer consumes one byte for the device |
| frm_tx_data | output | 8 | Byte sent to the device |
| usr_rx_valid | output | 1 | Payload byte available to the user |
| usr_rx_data | output | 8 | Payload byte to the user |
| usr_tx_take | output | 1 | User byte consumed this cycle |
| usr_tx_data | input | 8 | Next payload byte from the user |

## Verification
The bench builds the engine with LEN_W=12 and MAX_ZERO=4, and leaves FRAME_MAX at its real value of 64. The small retry limit lets the busy-exhaustion path be reached with four scripted status replies. A 150-byte transfer against a burst count of 200 then shows the frame cap cutting the buffer into 64, 64 and 22. Status words with junk in the outer bytes, a burst count of 0xFFFF, a burst count of one, and zero runs that stop one short of the limit cover the field extraction and the resetting of the retry count.

// File: rtl/fbm_pkg.sv
`timescale 1ns/1ps
package fbm_pkg;

    // Control sequence of one transfer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STS_REQ,
        ST_STS_DATA,
        ST_EVAL,
        ST_FIFO_REQ,
        ST_FIFO_DATA,
        ST_DONE,
        ST_FAIL
    } fbm_state_e;

    // Status register layout
    localparam int STS_FRAME_BYTES = 4;
    localparam int STS_WORD_BITS   = 8 * STS_FRAME_BYTES;
    localparam int BURST_LO        = 8;
    localparam int BURST_BITS      = 16;

    typedef struct packed {
        logic [BURST_BITS-1:0] count;
        logic                  busy;
    } burst_t;

    function automatic burst_t decode_burst(input logic [BURST_BITS-1:0] field);
        burst_t b;
        b.count = field;
        b.busy  = (field == '0);
        return b;
    endfunction

    function automatic logic [31:0] min3(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input logic [31:0] c);
        logic [31:0] m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

endpackage

// File: rtl/fbm_sts_capture.sv
`timescale 1ns/1ps
// Collects the status bytes (least significant first) and keeps only the
// bits from the burst field upward; the low byte falls out of the bottom.
module fbm_sts_capture
    import fbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    output logic [BURST_BITS-1:0] field,
    output logic                  last
);
    localparam int KEEP_BITS = STS_WORD_BITS - BURST_LO;
    localparam int IDX_W     = $clog2(STS_FRAME_BYTES);

    logic [KEEP_BITS-1:0] keep_q;
    logic [IDX_W-1:0]     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_q <= '0;
            idx_q  <= '0;
        end else if (clear) begin
            idx_q  <= '0;
        end else if (byte_valid) begin
            keep_q <= {byte_data, keep_q[KEEP_BITS-1:8]};
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    assign field = keep_q[BURST_BITS-1:0];
    assign last  = byte_valid && (idx_q == IDX_W'(STS_FRAME_BYTES - 1));

endmodule

// File: rtl/fbm_chunk_calc.sv
`timescale 1ns/1ps
// Chunk size: smallest of bytes remaining, live burst count and frame cap.
module fbm_chunk_calc
    import fbm_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int FRAME_MAX = 64,
    parameter int SIZE_W    = 7
) (
    input  logic [LEN_W-1:0]      remaining,
    input  logic [BURST_BITS-1:0] burst,
    output logic [SIZE_W-1:0]     chunk
);
    always_comb begin
        chunk = SIZE_W'(min3(32'(remaining), 32'(burst), 32'(FRAME_MAX)));
    end
endmodule

// File: rtl/fbm_zero_guard.sv
`timescale 1ns/1ps
// Counts consecutive busy status reads and flags the last one allowed.
module fbm_zero_guard #(
    parameter int MAX_ZERO = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic hit,
    output logic exhausted
);
    localparam int ZW = $clog2(MAX_ZERO + 1);

    logic [ZW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (hit) begin
            run_q <= run_q + ZW'(1);
        end
    end

    assign exhausted = (run_q == ZW'(MAX_ZERO - 1));
endmodule

// File: rtl/fifo_burst_mover.sv
`timescale 1ns/1ps
module fifo_burst_mover
    import fbm_pkg::*;
#(
    parameter int              LEN_W     = 16,
    parameter int              FRAME_MAX = 64,
    parameter int              MAX_ZERO  = 1024,
    parameter int              ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] STS_ADDR  = 24'hD40018,
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'hD40024,
    localparam int             SIZE_W    = $clog2(FRAME_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_read,
    input  logic [LEN_W-1:0]  total_len,
    output logic              done,
    output logic              error,
    output logic              frm_req,
    output logic              frm_read,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [SIZE_W-1:0] frm_size,
    input  logic              frm_ack,
    input  logic              frm_rx_valid,
    input  logic [7:0]        frm_rx_data,
    input  logic              frm_tx_ready,
    output logic [7:0]        frm_tx_data,
    output logic              usr_rx_valid,
    output logic [7:0]        usr_rx_data,
    output logic              usr_tx_take,
    input  logic [7:0]        usr_tx_data
);
    fbm_state_e            state;
    logic                  dir_q;
    logic [LEN_W-1:0]      remaining;
    logic [SIZE_W-1:0]     chunk_q;
    logic [SIZE_W-1:0]     beat_cnt;

    logic [BURST_BITS-1:0] burst_field;
    logic                  sts_last;
    burst_t                burst;
    logic [SIZE_W-1:0]     chunk_next;
    logic                  retry_spent;
    logic                  fifo_phase;
    logic                  beat;
    logic                  accept_start;

    assign accept_start = (state == ST_IDLE) && start;
    assign fifo_phase   = (state == ST_FIFO_REQ) || (state == ST_FIFO_DATA);
    assign beat         = (state == ST_FIFO_DATA) &&
                          (dir_q ? frm_rx_valid : frm_tx_ready);
    assign burst        = decode_burst(burst_field);

    fbm_sts_capture u_sts (
        .clk        (clk),
        .rst        (rst),
        .clear      (state == ST_STS_REQ),
        .byte_valid ((state == ST_STS_DATA) && frm_rx_valid),
        .byte_data  (frm_rx_data),
        .field      (burst_field),
        .last       (sts_last)
    );

    fbm_chunk_calc #(
        .LEN_W     (LEN_W),
        .FRAME_MAX (FRAME_MAX),
        .SIZE_W    (SIZE_W)
    ) u_chunk (
        .remaining (remaining),
        .burst     (burst.count),
        .chunk     (chunk_next)
    );

    fbm_zero_guard #(
        .MAX_ZERO (MAX_ZERO)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept_start || ((state == ST_EVAL) && !burst.busy)),
        .hit       ((state == ST_EVAL) && burst.busy),
        .exhausted (retry_spent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dir_q     <= 1'b0;
            remaining <= '0;
            chunk_q   <= '0;
            beat_cnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        dir_q     <= dir_read;
                        remaining <= total_len;
                        state     <= (total_len == '0) ? ST_DONE : ST_STS_REQ;
                    end
                end
                ST_STS_REQ: begin
                    if (frm_ack) state <= ST_STS_DATA;
                end
                ST_STS_DATA: begin
                    if (sts_last) state <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (burst.busy) begin
                        state <= retry_spent ? ST_FAIL : ST_STS_REQ;
                    end else begin
                        chunk_q <= chunk_next;
                        state   <= ST_FIFO_REQ;
                    end
                end
                ST_FIFO_REQ: begin
                    if (frm_ack) begin
                        beat_cnt <= '0;
                        state    <= ST_FIFO_DATA;
                    end
                end
                ST_FIFO_DATA: begin
                    if (beat) begin
                        remaining <= remaining - LEN_W'(1);
                        beat_cnt  <= beat_cnt + SIZE_W'(1);
                        if ((beat_cnt + SIZE_W'(1)) == chunk_q) begin
                            state <= (remaining == LEN_W'(1)) ? ST_DONE : ST_STS_REQ;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                ST_FAIL: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Framer request side
    assign frm_req  = (state == ST_STS_REQ) || (state == ST_FIFO_REQ);
    assign frm_read = fifo_phase ? dir_q : 1'b1;
    assign frm_addr = fifo_phase ? FIFO_ADDR : STS_ADDR;
    assign frm_size = fifo_phase ? chunk_q : SIZE_W'(STS_FRAME_BYTES);

    // Payload pass-through
    assign usr_rx_valid = (state == ST_FIFO_DATA) && dir_q && frm_rx_valid;
    assign usr_rx_data  = frm_rx_data;
    assign usr_tx_take  = (state == ST_FIFO_DATA) && !dir_q && frm_tx_ready;
    assign frm_tx_data  = usr_tx_data;

    assign done  = (state == ST_DONE);
    assign error = (state == ST_FAIL);

endmodule

// File: rtl/fbm_checker.sv
`timescale 1ns/1ps
module fbm_checker #(
    parameter int              ADDR_W    = 24,
    parameter int              SIZE_W    = 7,
    parameter int              FRAME_MAX = 64,
    parameter logic [ADDR_W-1:0] STS_ADDR  = 24'hD40018,
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'hD40024
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              error,
    input logic              frm_req,
    input logic              frm_read,
    input logic [ADDR_W-1:0] frm_addr,
    input logic [SIZE_W-1:0] frm_size,
    input logic              frm_ack,
    input logic              frm_rx_valid,
    input logic              frm_tx_ready,
    input logic              usr_rx_valid,
    input logic              usr_tx_take
);
    // R2
    sts_frame_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_req && frm_addr == STS_ADDR) |-> (frm_read && frm_size == SIZE_W'(4)));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_req && !frm_ack) |=> (frm_req && $stable(frm_addr) &&
                                   $stable(frm_size) && $stable(frm_read)));

    // R5
    chunk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_req && frm_addr == FIFO_ADDR) |->
            (frm_size != '0 && frm_size <= SIZE_W'(FRAME_MAX)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    error_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !error);

    // R9
    error_stop_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> (!error && !frm_req));

    // R10
    rx_forward_chk: assert property (@(posedge clk) disable iff (rst)
        usr_rx_valid |-> frm_rx_valid);

    // R11
    tx_take_chk: assert property (@(posedge clk) disable iff (rst)
        usr_tx_take |-> frm_tx_ready);

endmodule

bind fifo_burst_mover fbm_checker #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .FRAME_MAX (FRAME_MAX),
    .STS_ADDR  (STS_ADDR),
    .FIFO_ADDR (FIFO_ADDR)
) u_fbm_checker (
    .clk          (clk),
    .rst          (rst),
    .done         (done),
    .error        (error),
    .frm_req      (frm_req),
    .frm_read     (frm_read),
    .frm_addr     (frm_addr),
    .frm_size     (frm_size),
    .frm_ack      (frm_ack),
    .frm_rx_valid (frm_rx_valid),
    .frm_tx_ready (frm_tx_ready),
    .usr_rx_valid (usr_rx_valid),
    .usr_tx_take  (usr_tx_take)
);

// File: tb/test_fifo_burst_mover.sv
`timescale 1ns/1ps
module test_fifo_burst_mover;
    localparam int LEN_W     = 12;
    localparam int FRAME_MAX = 64;
    localparam int MAX_ZERO  = 4;
    localparam int ADDR_W    = 24;
    localparam int SIZE_W    = $clog2(FRAME_MAX + 1);
    localparam logic [ADDR_W-1:0] STS  = 24'hD40018;
    localparam logic [ADDR_W-1:0] FIFO = 24'hD40024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              dir_read = 1'b0;
    logic [LEN_W-1:0]  total_len = '0;
    logic              done, error;
    logic              frm_req, frm_read;
    logic [ADDR_W-1:0] frm_addr;
    logic [SIZE_W-1:0] frm_size;
    logic              frm_ack = 1'b0;
    logic              frm_rx_valid = 1'b0;
    logic [7:0]        frm_rx_data = '0;
    logic              frm_tx_ready = 1'b0;
    logic [7:0]        frm_tx_data;
    logic              usr_rx_valid;
    logic [7:0]        usr_rx_data;
    logic              usr_tx_take;
    logic [7:0]        usr_tx_data = '0;

    fifo_burst_mover #(
        .LEN_W     (LEN_W),
        .FRAME_MAX (FRAME_MAX),
        .MAX_ZERO  (MAX_ZERO),
        .ADDR_W    (ADDR_W),
        .STS_ADDR  (STS),
        .FIFO_ADDR (FIFO)
    ) i_fifo_burst_mover (
        .clk(clk), .rst(rst), .start(start), .dir_read(dir_read),
        .total_len(total_len), .done(done), .error(error),
        .frm_req(frm_req), .frm_read(frm_read), .frm_addr(frm_addr),
        .frm_size(frm_size), .frm_ack(frm_ack), .frm_rx_valid(frm_rx_valid),
        .frm_rx_data(frm_rx_data), .frm_tx_ready(frm_tx_ready),
        .frm_tx_data(frm_tx_data), .usr_rx_valid(usr_rx_valid),
        .usr_rx_data(usr_rx_data), .usr_tx_take(usr_tx_take),
        .usr_tx_data(usr_tx_data)
    );

    always #2.5 clk = ~clk;

    integer vectors = 0;
    integer miscompares = 0;
    integer done_cnt = 0;
    integer err_cnt = 0;
    integer cycles = 0;
    bit     m_fifo_rd = 1'b0;
    bit     m_fifo_wr = 1'b0;
    logic [31:0] sts_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model compared on every clock, away from the edges
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (done)  done_cnt++;
            if (error) err_cnt++;
            chk(usr_rx_valid == (frm_rx_valid && m_fifo_rd), "R10 rx forwarding",
                usr_rx_valid, frm_rx_valid && m_fifo_rd);
            if (usr_rx_valid)
                chk(usr_rx_data == frm_rx_data, "R10 rx byte", usr_rx_data, frm_rx_data);
            chk(usr_tx_take == (frm_tx_ready && m_fifo_wr), "R11 tx take",
                usr_tx_take, frm_tx_ready && m_fifo_wr);
            if (usr_tx_take)
                chk(frm_tx_data == usr_tx_data, "R11 tx byte", frm_tx_data, usr_tx_data);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            miscompares++;
            $display("FAIL R7 watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_req(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200 && !ok; i++) begin
            @(negedge clk);
            #1;
            if (frm_req) ok = 1'b1;
        end
    endtask

    // Framer model: one byte per beat, with a stall before every third byte
    task automatic send_bytes(input int n, input bit rd, input bit fifo,
                              input logic [31:0] word, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frm_ack = 1'b0;
            if (fifo) begin
                m_fifo_rd = rd;
                m_fifo_wr = !rd;
            end
            if (i % 3 == 1) begin
                frm_rx_valid = 1'b0;
                frm_tx_ready = 1'b0;
                @(negedge clk);
            end
            if (!fifo) begin
                frm_rx_valid = 1'b1;
                frm_rx_data  = word[8*i +: 8];
            end else if (rd) begin
                frm_rx_valid = 1'b1;
                frm_rx_data  = 8'((base + i) * 7 + 3);
            end else begin
                frm_tx_ready = 1'b1;
                usr_tx_data  = 8'((base + i) * 5 + 1);
            end
        end
        @(negedge clk);
        frm_rx_valid = 1'b0;
        frm_tx_ready = 1'b0;
        frm_ack      = 1'b0;
        m_fifo_rd    = 1'b0;
        m_fifo_wr    = 1'b0;
    endtask

    task automatic run_xfer(input bit rd, input int len, input bit noise);
        int rem = len;
        int zero_run = 0;
        int chunk = 0;
        int burst = 0;
        int base = 0;
        int d0 = done_cnt;
        int e0 = err_cnt;
        bit want_sts = 1'b1;
        bit ok;
        logic [31:0] w;

        @(negedge clk);
        start = 1'b1; dir_read = rd; total_len = LEN_W'(len);
        @(negedge clk);
        if (noise) begin
            start = 1'b1; dir_read = !rd; total_len = LEN_W'(1);
            @(negedge clk);
        end
        start = 1'b0; total_len = '0;
        if (len == 0) begin
            #1;
            chk(done == 1'b1, "R8 zero length done", done, 1);
            chk(frm_req == 1'b0, "R8 no request", frm_req, 0);
        end
        while (rem > 0) begin
            wait_req(ok);
            chk(ok, "R2 request expected", ok, 1);
            if (!ok) return;
            if (want_sts) begin
                chk(frm_addr == STS && frm_read && frm_size == SIZE_W'(4),
                    "R2,R4 status frame", {frm_addr, frm_read, frm_size}, {STS, 1'b1, 7'd4});
                w = (sts_q.size() != 0) ? sts_q.pop_front() : 32'h0000_4000;
                frm_ack = 1'b1;
                send_bytes(4, 1'b1, 1'b0, w, 0);
                burst = int'(w[23:8]);
                if (burst == 0) begin
                    zero_run++;
                    if (zero_run == MAX_ZERO) begin
                        for (int k = 0; k < 4; k++) begin
                            @(negedge clk);
                            #1;
                            chk(!frm_req, "R9 halted after busy limit", frm_req, 0);
                        end
                        chk(err_cnt - e0 == 1, "R9 error pulse", err_cnt - e0, 1);
                        chk(done_cnt == d0, "R9 no done", done_cnt - d0, 0);
                        return;
                    end
                end else begin
                    zero_run = 0;
                    chunk = rem;
                    if (burst < chunk) chunk = burst;
                    if (FRAME_MAX < chunk) chunk = FRAME_MAX;
                    want_sts = 1'b0;
                end
            end else begin
                chk(frm_addr == FIFO, "R6 fifo address", frm_addr, FIFO);
                chk(frm_read == rd, "R6 direction", frm_read, rd);
                chk(int'(frm_size) == chunk, "R5,R3 chunk size", frm_size, chunk);
                frm_ack = 1'b1;
                send_bytes(chunk, rd, 1'b1, 32'h0, base);
                base += chunk;
                rem  -= chunk;
                want_sts = 1'b1;
                if (rem == 0) begin
                    #1;
                    chk(done == 1'b1, "R7 done timing", done, 1);
                end
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(!frm_req, "R7 no request after done", frm_req, 0);
        end
        chk(done_cnt - d0 == 1, "R7 single done", done_cnt - d0, 1);
        chk(err_cnt == e0, "R7 no error", err_cnt - e0, 0);
        if (noise) chk(base == len, "R12 busy start ignored", base, len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!frm_req && !done && !error && !usr_tx_take && !usr_rx_valid,
            "R1 reset state", {frm_req, done, error, usr_tx_take, usr_rx_valid}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!frm_req && !done && !error, "R1 after reset", {frm_req, done, error}, 0);

        // R3: junk in outer bytes, burst 7 -> 7 then 3
        sts_q.push_back(32'hA5_0007_C3);
        run_xfer(1'b0, 10, 1'b0);

        // R5: frame cap -> 64, 64, 22
        sts_q.push_back(32'h0000_C800);
        sts_q.push_back(32'h0000_C800);
        sts_q.push_back(32'h0000_C800);
        run_xfer(1'b1, 150, 1'b0);

        // R4: busy runs just under the limit, run count resets per chunk
        sts_q.push_back(32'h0); sts_q.push_back(32'hFF00_00FF); sts_q.push_back(32'h0);
        sts_q.push_back(32'h0000_0500);
        sts_q.push_back(32'h0); sts_q.push_back(32'h0); sts_q.push_back(32'h0);
        sts_q.push_back(32'h0001_0000);
        run_xfer(1'b1, 8, 1'b0);

        // R8: zero length
        run_xfer(1'b0, 0, 1'b0);

        // R9: busy limit reached
        sts_q.push_back(32'h0); sts_q.push_back(32'h0);
        sts_q.push_back(32'h0); sts_q.push_back(32'h0);
        run_xfer(1'b1, 5, 1'b0);

        // R12: restart attempt while busy
        run_xfer(1'b0, 3, 1'b1);

        // Burst of one: three single-byte chunks
        sts_q.push_back(32'h0000_0100);
        sts_q.push_back(32'h0000_0100);
        sts_q.push_back(32'h0000_0100);
        run_xfer(1'b1, 3, 1'b0);

        // Full 16-bit burst field: cap and remainder decide
        sts_q.push_back(32'h00FF_FF00);
        sts_q.push_back(32'h00FF_FF00);
        run_xfer(1'b0, 70, 1'b0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule